// File: doc/BRIEF.md
# Push-Button Edge Capture Port with Interrupt

This block connects a few active-low push-button lines to a simple register bus. Each line is resampled into the system clock domain. A transition from high to low on a sampled line is recorded in a sticky per-line capture bit. The bit stays set until software writes a 1 to that bit position to clear it. A per-line enable mask selects which captured presses drive a level interrupt request. Software reads the live line levels, programs the mask, and acknowledges presses through four word-addressed registers.

A typical handler reads the capture register to find which buttons were pressed. It then writes the same value back to clear them. The request line falls one cycle after the last enabled capture bit is cleared. A press that lands in the same cycle as a clear is kept, so no event is lost.

Top module: `btn_edge_port`

## Requirements
- R1: After reset, `irq_o` and `bus_rvalid_o` are 0, and the mask and capture registers read as all zeros.
- R2: A read at offset 0 returns the synchronized level of each input line in bits WIDTH-1:0, with all upper bits 0. A read at offset 1 always returns 0, because every line is an input.
- R3: A high-to-low transition on line i sets capture bit i. The bit is set on the third rising clock edge after the pin changes. A low-to-high transition sets nothing.
- R4: A capture bit stays set after its line returns high, until software clears it.
- R5: Writing to offset 3 clears each capture bit whose write-data bit is 1 and leaves every other capture bit unchanged.
- R6: When a new falling edge on line i and a clear of bit i happen on the same clock edge, bit i stays set.
- R7: Offset 2 is the interrupt mask. A write stores bits WIDTH-1:0 of the write data, and a read returns the stored value with upper bits 0.
- R8: `irq_o` is registered and equals the OR of (capture AND mask) from the previous cycle. It therefore rises one cycle after an enabled bit is captured and falls one cycle after the last enabled bit is cleared or masked. A captured press with its mask bit at 0 raises no request.
- R9: Read data is presented one cycle after `bus_rd_i`, with `bus_rvalid_o` high for exactly that one cycle.
- R10: Writes to offsets 0 and 1 change no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pins_ni | input | WIDTH | Active-low button lines, asynchronous to clk_i |
| bus_addr_i | input | 2 | Word offset of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_rdata_o | output | BUS_W | Read data, valid when bus_rvalid_o is high |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| irq_o | output | 1 | Level interrupt request |

## Verification
The capture bit is written on the third rising edge after a pin change, and `irq_o` follows on the fourth. The bench changes pins on a falling clock edge and counts rising edges from that point. It checks that `irq_o` is still low after three edges and high after four. A clear or mask write takes effect on the rising edge where the write strobe is sampled, so `irq_o` is checked one half-cycle later (still high) and one full cycle after that (low). Reads are checked on the falling edge that follows the sampled read strobe, which is where the data and `bus_rvalid_o` are due. The set-wins case places the clear strobe on the exact edge where the detected fall reaches the capture register.

// File: rtl/btn_edge_pkg.sv
package btn_edge_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    OFS_LEVEL = 2'd0,
    OFS_DIR   = 2'd1,
    OFS_MASK  = 2'd2,
    OFS_EDGE  = 2'd3
  } reg_ofs_e;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_ni,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] fall_o
);

  localparam int DEPTH = STAGES + 1;

  logic [WIDTH-1:0] chain_q [DEPTH];
  logic [WIDTH-1:0] chain_d [DEPTH];

  always_comb begin
    chain_d[0] = pins_ni;
    for (int k = 1; k < DEPTH; k++) begin
      chain_d[k] = chain_q[k-1];
    end
  end

  // Idle lines are high, so the chain resets to ones and no fall is seen at release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) chain_q[k] <= '1;
    end else begin
      for (int k = 0; k < DEPTH; k++) chain_q[k] <= chain_d[k];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/btn_capture.sv
module btn_capture #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] fall_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic             mask_we_i,
  input  logic [WIDTH-1:0] mask_wdata_i,
  output logic [WIDTH-1:0] cap_o,
  output logic [WIDTH-1:0] mask_o,
  output logic             irq_o
);

  logic [WIDTH-1:0] cap_q, cap_d;
  logic [WIDTH-1:0] mask_q;
  logic             irq_q, irq_d;

  always_comb begin
    // A fall on the same edge as a clear keeps the bit set.
    cap_d = (cap_q & ~clr_i) | fall_i;
    irq_d = |(cap_q & mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_wdata_i;
    end
  end

  assign cap_o  = cap_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  a_r3_fall_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i != '0) |=> ((cap_q & $past(fall_i)) == $past(fall_i)));

  a_r4_bits_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q != '0) |=> (($past(cap_q) & ~$past(clr_i) & ~cap_q) == '0));

  a_r5_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~fall_i) != '0) |=> ((cap_q & $past(clr_i & ~fall_i)) == '0));

  a_r7_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));

  a_r7_mask_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> (mask_q == $past(mask_wdata_i)));

  a_r8_irq_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cap_q & mask_q) != '0) |=> irq_o);

  a_r8_irq_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cap_q & mask_q) == '0) |=> !irq_o);

endmodule

// File: rtl/btn_regif.sv
module btn_regif
  import btn_edge_pkg::*;
#(
  parameter int WIDTH = 2,
  parameter int BUS_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_i,
  input  logic [BUS_W-1:0]      wdata_i,
  input  logic                  rd_i,
  input  logic [WIDTH-1:0]      level_i,
  input  logic [WIDTH-1:0]      mask_i,
  input  logic [WIDTH-1:0]      cap_i,
  output logic                  mask_we_o,
  output logic [WIDTH-1:0]      mask_wdata_o,
  output logic [WIDTH-1:0]      clr_o,
  output logic [BUS_W-1:0]      rdata_o,
  output logic                  rvalid_o
);

  reg_ofs_e         ofs;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic             rvalid_q;

  assign ofs = reg_ofs_e'(addr_i);

  always_comb begin
    mask_we_o    = wr_i && (ofs == OFS_MASK);
    mask_wdata_o = wdata_i[WIDTH-1:0];
    clr_o        = (wr_i && (ofs == OFS_EDGE)) ? wdata_i[WIDTH-1:0] : '0;
  end

  always_comb begin
    rdata_d = '0;
    case (ofs)
      OFS_LEVEL: rdata_d[WIDTH-1:0] = level_i;
      OFS_MASK:  rdata_d[WIDTH-1:0] = mask_i;
      OFS_EDGE:  rdata_d[WIDTH-1:0] = cap_i;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= rd_i;
  end

  generate
    if (BUS_W > WIDTH) begin : g_unused_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[BUS_W-1:WIDTH];
    end
  endgenerate

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  a_r9_rvalid_follows_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  a_r9_rvalid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);

  a_r10_ro_writes_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ((ofs == OFS_LEVEL) || (ofs == OFS_DIR))) |-> (!mask_we_o && (clr_o == '0)));

endmodule

// File: rtl/btn_edge_port.sv
module btn_edge_port
  import btn_edge_pkg::*;
#(
  parameter int WIDTH       = 2,
  parameter int BUS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WIDTH-1:0]      pins_ni,
  input  logic [REG_ADDR_W-1:0] bus_addr_i,
  input  logic                  bus_wr_i,
  input  logic [BUS_W-1:0]      bus_wdata_i,
  input  logic                  bus_rd_i,
  output logic [BUS_W-1:0]      bus_rdata_o,
  output logic                  bus_rvalid_o,
  output logic                  irq_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [WIDTH-1:0] level;
  logic [WIDTH-1:0] fall;
  logic [WIDTH-1:0] cap;
  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] clr;
  logic             mask_we;
  logic [WIDTH-1:0] mask_wdata;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  btn_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .pins_ni (pins_ni),
    .level_o (level),
    .fall_o  (fall)
  );

  btn_capture #(.WIDTH(WIDTH)) u_capture (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .fall_i       (fall),
    .clr_i        (clr),
    .mask_we_i    (mask_we),
    .mask_wdata_i (mask_wdata),
    .cap_o        (cap),
    .mask_o       (mask),
    .irq_o        (irq_o)
  );

  btn_regif #(.WIDTH(WIDTH), .BUS_W(BUS_W)) u_regif (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .addr_i       (bus_addr_i),
    .wr_i         (bus_wr_i),
    .wdata_i      (bus_wdata_i),
    .rd_i         (bus_rd_i),
    .level_i      (level),
    .mask_i       (mask),
    .cap_i        (cap),
    .mask_we_o    (mask_we),
    .mask_wdata_o (mask_wdata),
    .clr_o        (clr),
    .rdata_o      (bus_rdata_o),
    .rvalid_o     (bus_rvalid_o)
  );

endmodule

// File: tb/btn_edge_port_test.sv
module btn_edge_port_test;

  localparam int WIDTH = 2;
  localparam int BUS_W = 32;

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] pins;
  logic [1:0]       addr;
  logic             wr;
  logic [BUS_W-1:0] wdata;
  logic             rd;
  logic [BUS_W-1:0] rdata;
  logic             rvalid;
  logic             irq;

  int checks;
  int fails;

  btn_edge_port #(.WIDTH(WIDTH), .BUS_W(BUS_W)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pins_ni      (pins),
    .bus_addr_i   (addr),
    .bus_wr_i     (wr),
    .bus_wdata_i  (wdata),
    .bus_rd_i     (rd),
    .bus_rdata_o  (rdata),
    .bus_rvalid_o (rvalid),
    .irq_o        (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_pins(input logic [WIDTH-1:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] v, output logic vld);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(posedge clk);
    #1 rd = 1'b0;
    @(negedge clk);
    v = rdata; vld = rvalid;
  endtask

  task automatic press_release(input logic [WIDTH-1:0] pressed);
    set_pins(pressed);
    wait_cycles(6);
    set_pins('1);
    wait_cycles(6);
  endtask

  task automatic t_reset;
    logic [31:0] v; logic vld;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(rvalid == 1'b0, "R1 rvalid after reset", rvalid, 0);
    bus_read(2'd2, v, vld);
    check(v == 0, "R1 mask after reset", v, 0);
    bus_read(2'd3, v, vld);
    check(v == 0, "R1 capture after reset", v, 0);
  endtask

  task automatic t_level_read;
    logic [31:0] v; logic vld;
    bus_read(2'd0, v, vld);
    check(v == 32'h3, "R2 idle level", v, 32'h3);
    set_pins(2'b01);
    wait_cycles(4);
    bus_read(2'd0, v, vld);
    check(v == 32'h1, "R2 level line1 low", v, 32'h1);
    bus_read(2'd1, v, vld);
    check(v == 0, "R2 direction reads zero", v, 0);
    set_pins('1);
    wait_cycles(4);
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd3, v, vld);
    check(v == 0, "R5 clear all", v, 0);
  endtask

  task automatic t_capture;
    logic [31:0] v; logic vld;
    set_pins(2'b10);
    wait_cycles(6);
    check(irq == 1'b0, "R8 masked press gives no irq", irq, 0);
    set_pins('1);
    wait_cycles(6);
    bus_read(2'd3, v, vld);
    check(v == 32'h1, "R3 R4 fall captured and held, rise ignored", v, 32'h1);
  endtask

  task automatic t_clear;
    logic [31:0] v; logic vld;
    press_release(2'b01);
    bus_read(2'd3, v, vld);
    check(v == 32'h3, "R3 both captured", v, 32'h3);
    bus_write(2'd3, 32'h1);
    bus_read(2'd3, v, vld);
    check(v == 32'h2, "R5 clear bit0 only", v, 32'h2);
    bus_write(2'd3, 32'h2);
    bus_read(2'd3, v, vld);
    check(v == 0, "R5 clear bit1", v, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v; logic vld;
    bus_write(2'd2, 32'hFFFF_FFFE);
    bus_read(2'd2, v, vld);
    check(v == 32'h2, "R7 mask readback", v, 32'h2);
    press_release(2'b10);
    check(irq == 1'b0, "R8 bit0 masked off", irq, 0);
    set_pins(2'b01);
    wait_cycles(3);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq not before fourth edge", irq, 0);
    @(posedge clk); @(negedge clk);
    check(irq == 1'b1, "R8 irq on fourth edge", irq, 1);
    set_pins('1);
    wait_cycles(4);
    bus_write(2'd3, 32'h2);
    @(negedge clk);
    check(irq == 1'b1, "R8 irq held on clear edge", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq drops one cycle after clear", irq, 0);
    press_release(2'b01);
    check(irq == 1'b1, "R8 irq again", irq, 1);
    bus_write(2'd2, 32'h0);
    @(negedge clk);
    check(irq == 1'b1, "R8 irq held on mask edge", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq drops one cycle after masking", irq, 0);
    bus_write(2'd3, 32'h3);
  endtask

  task automatic t_set_wins;
    logic [31:0] v; logic vld;
    press_release(2'b10);
    set_pins(2'b10);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    addr = 2'd3; wdata = 32'h1; wr = 1'b1;
    @(posedge clk);
    #1 wr = 1'b0;
    bus_read(2'd3, v, vld);
    check(v == 32'h1, "R6 fall beats clear", v, 32'h1);
    set_pins('1);
    wait_cycles(6);
    bus_write(2'd3, 32'h1);
    bus_read(2'd3, v, vld);
    check(v == 0, "R5 plain clear", v, 0);
  endtask

  task automatic t_read_timing;
    logic [31:0] v; logic vld;
    @(negedge clk);
    check(rvalid == 1'b0, "R9 rvalid idle", rvalid, 0);
    bus_read(2'd0, v, vld);
    check(vld == 1'b1, "R9 rvalid one cycle after rd", vld, 1);
    check(v == 32'h3, "R9 data with rvalid", v, 32'h3);
    @(negedge clk);
    check(rvalid == 1'b0, "R9 rvalid single cycle", rvalid, 0);
  endtask

  task automatic t_ignored;
    logic [31:0] v; logic vld;
    bus_write(2'd2, 32'h1);
    press_release(2'b01);
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd0, v, vld);
    check(v == 32'h3, "R10 level unaffected", v, 32'h3);
    bus_read(2'd1, v, vld);
    check(v == 0, "R10 direction unaffected", v, 0);
    bus_read(2'd2, v, vld);
    check(v == 32'h1, "R10 mask unaffected", v, 32'h1);
    bus_read(2'd3, v, vld);
    check(v == 32'h2, "R10 capture unaffected", v, 32'h2);
  endtask

  initial begin
    checks = 0; fails = 0;
    pins = '1; addr = '0; wr = 1'b0; wdata = '0; rd = 1'b0;
    rst_n = 1'b0;
    wait_cycles(4);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cycles(4);
    t_reset();
    t_level_read();
    t_capture();
    t_clear();
    t_irq();
    t_set_wins();
    t_read_timing();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cycles(20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule